// File: doc/BRIEF.md
# Per-Pin Drive Waveform Formatter

This block shapes the drive waveform of a single tester pin for each vector period. At the start of every vector the sequencer gives it a drive code, a waveform format and two phase selections. The selections pick the assert and return edge times from a set of programmable phase values. A tick counter restarts on each vector start. The block compares the tick count with the chosen edges and produces a registered pin level and a registered output enable. The enable controls the pin's tri-state driver.

A system instantiates one copy per pin, so each pin chooses its format independently. Each copy remembers the data bit it last drove. This lets a vector reuse that bit or invert it without the sequencer resending it. Analog levels, load currents, timing-set storage and vector sequencing sit outside the block. Their results reach the block as plain inputs.

Top module: `pin_drive_formatter`

## Requirements
- R1: After reset, and until the first vector start, `pin_oe` is 0 and `pin_out` is 0.
- R2: The cycle in which `vec_start` is high is tick 0 of a new vector. Each later clock adds one tick, and the count saturates at its maximum. A level or enable change caused by tick t appears on the pins one clock after the tick-t cycle.
- R3: The assert edge is `phase_times` entry `assert_sel` and the return edge is entry `return_sel`. Entry k occupies bits [k*TICK_W +: TICK_W]. The selections, drive code and format are sampled only in the `vec_start` cycle and hold for the whole vector.
- R4: Drive codes are 0 = drive low, 1 = drive high, 3 = keep (reuse the last data bit) and 4 = toggle (invert the last data bit). The data bit after reset is 0. A high-impedance vector leaves the stored data bit unchanged.
- R5: Drive code 2 (high impedance) holds `pin_oe` at 0 for every tick of the vector, whatever the format, and `pin_out` keeps its previous value.
- R6: Format 0 (no return): before the assert edge the pin keeps its previous level and enable. From the assert edge to the end of the vector it drives the data bit with `pin_oe` = 1, and the return edge is ignored.
- R7: Format 1 (return to 1) and format 2 (return to 0) keep `pin_oe` at 1. They drive the data bit for ticks in [assert, return) and drive 1 or 0 respectively at every other tick.
- R8: Format 3 (return to high impedance) drives the data bit with `pin_oe` = 1 for ticks in [assert, return). At every other tick it holds `pin_oe` at 0 and keeps `pin_out`.
- R9: Format 4 (return to complement): before the assert edge the pin keeps its previous level and enable. It drives the data bit for ticks in [assert, return), then drives its complement with `pin_oe` = 1 from the later of the two edges to the end of the vector.
- R10: Format 5 (surround by complement) keeps `pin_oe` at 1. It drives the complement of the data bit before the assert edge, the data bit in [assert, return), and the complement again afterwards.
- R11: When the return edge equals or precedes the assert edge, the data window is empty: the return edge wins and no data pulse appears.
- R12: Format codes 6 and 7 behave as format 0. Drive codes 5 to 7 behave as drive code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_start | input | 1 | Marks tick 0 of a vector; vector inputs sampled here |
| drv_code | input | 3 | Drive code of the vector |
| fmt_sel | input | 3 | Waveform format of this pin |
| phase_times | input | PHASES*TICK_W | Phase edge times of the active timing set, in ticks |
| assert_sel | input | SEL_W | Index of the phase used as assert edge |
| return_sel | input | SEL_W | Index of the phase used as return edge |
| pin_out | output | 1 | Registered pin drive level |
| pin_oe | output | 1 | Registered pin output enable |

## Verification
The block has three pieces of internal state: the tick count, the latched edge selections and the remembered data bit. A tick count that is off by one shifts every edge of the vector by a clock. The per-tick comparison shows this at the first edge, a single cycle late or early. A latched selection that drifts during a vector moves an edge while the sequencer's inputs have already changed, so the bench scrambles those inputs after tick 0. A wrong stored data bit does not show in the vector that corrupts it. It shows in the next keep or toggle vector, at its first driven tick, and surround-by-complement exposes it one clock after tick 0.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

   typedef enum logic [2:0] {
      DRV_LO   = 3'd0,
      DRV_HI   = 3'd1,
      DRV_Z    = 3'd2,
      DRV_KEEP = 3'd3,
      DRV_TOG  = 3'd4
   } drv_code_e;

   typedef enum logic [2:0] {
      FMT_NR  = 3'd0,
      FMT_R1  = 3'd1,
      FMT_R0  = 3'd2,
      FMT_RZ  = 3'd3,
      FMT_RC  = 3'd4,
      FMT_SBC = 3'd5
   } fmt_e;

   localparam int MIN_TICK_W = 16;

endpackage

// File: rtl/pdf_tick_counter.sv
module pdf_tick_counter #(
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_start,
   output logic [TICK_W-1:0] tick
);
   localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

   logic [TICK_W-1:0] cnt_q;

   always_comb begin
      if (vec_start)
         tick = '0;
      else if (cnt_q == TICK_MAX)
         tick = TICK_MAX;
      else
         tick = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= tick;
   end

   p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vec_start |=> (cnt_q == '0));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_start && cnt_q != TICK_MAX) |=> (cnt_q == TICK_W'($past(cnt_q) + 1'b1)));

   p_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_start && cnt_q == TICK_MAX) |=> (cnt_q == TICK_MAX));

endmodule

// File: rtl/pdf_edge_select.sv
module pdf_edge_select #(
   parameter int TICK_W = 16,
   parameter int PHASES = 4,
   parameter int SEL_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [PHASES*TICK_W-1:0] phase_vec,
   input  logic [SEL_W-1:0]         a_sel,
   input  logic [SEL_W-1:0]         r_sel,
   output logic [TICK_W-1:0]        t_assert,
   output logic [TICK_W-1:0]        t_return
);
   logic [TICK_W-1:0] ph [PHASES];
   logic [TICK_W-1:0] a_now, r_now;
   logic [TICK_W-1:0] a_q, r_q;

   for (genvar g = 0; g < PHASES; g++) begin : g_slice
      assign ph[g] = phase_vec[g*TICK_W +: TICK_W];
   end

   if (PHASES == 1) begin : g_single
      assign a_now = ph[0];
      assign r_now = ph[0];
   end else if (PHASES == (1 << SEL_W)) begin : g_full
      assign a_now = ph[a_sel];
      assign r_now = ph[r_sel];
   end else begin : g_guarded
      assign a_now = (int'(a_sel) < PHASES) ? ph[a_sel] : ph[0];
      assign r_now = (int'(r_sel) < PHASES) ? ph[r_sel] : ph[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         r_q <= '0;
      end else if (load) begin
         a_q <= a_now;
         r_q <= r_now;
      end
   end

   assign t_assert = load ? a_now : a_q;
   assign t_return = load ? r_now : r_q;

   p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load ##1 !load) |-> ($stable(t_assert) && $stable(t_return)));

endmodule

// File: rtl/pdf_data_track.sv
module pdf_data_track
   import pdf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [2:0] code_in,
   output logic       drive_en,
   output logic       data_act
);
   logic       en_q, data_q;
   logic       en_new, data_new;

   always_comb begin
      en_new   = 1'b1;
      data_new = data_q;
      case (code_in)
         DRV_LO:   data_new = 1'b0;
         DRV_HI:   data_new = 1'b1;
         DRV_KEEP: data_new = data_q;
         DRV_TOG:  data_new = ~data_q;
         default:  en_new   = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         data_q <= 1'b0;
      end else if (load) begin
         en_q   <= en_new;
         data_q <= data_new;
      end
   end

   assign drive_en = load ? en_new   : en_q;
   assign data_act = load ? data_new : data_q;

   p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && code_in == DRV_TOG) |=> (data_q != $past(data_q)));

   p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && code_in == DRV_KEEP) |=> $stable(data_q));

   p_hiz_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && code_in == DRV_Z) |=> $stable(data_q));

endmodule

// File: rtl/pdf_format_core.sv
module pdf_format_core
   import pdf_pkg::*;
#(
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [2:0]        fmt_in,
   input  logic              drive_en,
   input  logic              data_act,
   input  logic [TICK_W-1:0] tick,
   input  logic [TICK_W-1:0] t_assert,
   input  logic [TICK_W-1:0] t_return,
   output logic              pin_out,
   output logic              pin_oe
);
   fmt_e fmt_q, fmt_dec, fmt_act;
   logic past_a, in_win;
   logic out_q, oe_q, out_d, oe_d;

   assign fmt_dec = (fmt_in <= 3'd5) ? fmt_e'(fmt_in) : FMT_NR;
   assign fmt_act = load ? fmt_dec : fmt_q;

   assign past_a = (tick >= t_assert);
   assign in_win = past_a && (tick < t_return);

   always_comb begin
      out_d = out_q;
      oe_d  = oe_q;
      if (!drive_en) begin
         oe_d = 1'b0;
      end else begin
         case (fmt_act)
            FMT_R1: begin
               oe_d  = 1'b1;
               out_d = in_win ? data_act : 1'b1;
            end
            FMT_R0: begin
               oe_d  = 1'b1;
               out_d = in_win ? data_act : 1'b0;
            end
            FMT_RZ: begin
               oe_d = in_win;
               if (in_win) out_d = data_act;
            end
            FMT_RC: begin
               if (past_a) begin
                  oe_d  = 1'b1;
                  out_d = in_win ? data_act : ~data_act;
               end
            end
            FMT_SBC: begin
               oe_d  = 1'b1;
               out_d = in_win ? data_act : ~data_act;
            end
            default: begin
               if (past_a) begin
                  oe_d  = 1'b1;
                  out_d = data_act;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q <= FMT_NR;
         out_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         if (load) fmt_q <= fmt_dec;
         out_q <= out_d;
         oe_q  <= oe_d;
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = oe_q;

   p_hiz_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |=> !pin_oe);

   p_nr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && !load && fmt_act == FMT_NR && tick > t_assert) |=> $stable(pin_out));

   p_rail_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && (fmt_act == FMT_R1 || fmt_act == FMT_R0)) |=> pin_oe);

   p_sbc_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && fmt_act == FMT_SBC) |=> pin_oe);

endmodule

// File: rtl/pin_drive_formatter.sv
module pin_drive_formatter
   import pdf_pkg::*;
#(
   parameter int TICK_W = 16,
   parameter int PHASES = 4,
   localparam int SEL_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vec_start,
   input  logic [2:0]               drv_code,
   input  logic [2:0]               fmt_sel,
   input  logic [PHASES*TICK_W-1:0] phase_times,
   input  logic [SEL_W-1:0]         assert_sel,
   input  logic [SEL_W-1:0]         return_sel,
   output logic                     pin_out,
   output logic                     pin_oe
);
   if (TICK_W < MIN_TICK_W) begin : g_chk_tick
      $error("pin_drive_formatter: TICK_W below minimum edge range");
   end
   if (PHASES < 1) begin : g_chk_phases
      $error("pin_drive_formatter: PHASES must be at least 1");
   end

   logic [TICK_W-1:0] tick, t_assert, t_return;
   logic              drive_en, data_act;

   pdf_tick_counter #(.TICK_W(TICK_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .vec_start (vec_start),
      .tick      (tick)
   );

   pdf_edge_select #(.TICK_W(TICK_W), .PHASES(PHASES), .SEL_W(SEL_W)) u_edges (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (vec_start),
      .phase_vec (phase_times),
      .a_sel     (assert_sel),
      .r_sel     (return_sel),
      .t_assert  (t_assert),
      .t_return  (t_return)
   );

   pdf_data_track u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (vec_start),
      .code_in  (drv_code),
      .drive_en (drive_en),
      .data_act (data_act)
   );

   pdf_format_core #(.TICK_W(TICK_W)) u_fmt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (vec_start),
      .fmt_in   (fmt_sel),
      .drive_en (drive_en),
      .data_act (data_act),
      .tick     (tick),
      .t_assert (t_assert),
      .t_return (t_return),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!pin_oe && !pin_out));

endmodule

// File: tb/pin_drive_formatter_bench.sv
`timescale 1ns/1ps
module pin_drive_formatter_bench;
   localparam int TICK_W = 16;
   localparam int PHASES = 4;
   localparam int SEL_W  = 2;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     vec_start = 1'b0;
   logic [2:0]               drv_code = 3'd2;
   logic [2:0]               fmt_sel = 3'd0;
   logic [PHASES*TICK_W-1:0] phase_times;
   logic [SEL_W-1:0]         assert_sel = '0;
   logic [SEL_W-1:0]         return_sel = '0;
   logic                     pin_out, pin_oe;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   int ph [PHASES] = '{0, 2, 5, 5};
   logic m_data = 1'b0, m_out = 1'b0, m_oe = 1'b0;

   always #4 clk = ~clk;

   assign phase_times = {16'(ph[3]), 16'(ph[2]), 16'(ph[1]), 16'(ph[0])};

   pin_drive_formatter #(.TICK_W(TICK_W), .PHASES(PHASES)) u_pin_drive_formatter (
      .clk         (clk),
      .rst_n       (rst_n),
      .vec_start   (vec_start),
      .drv_code    (drv_code),
      .fmt_sel     (fmt_sel),
      .phase_times (phase_times),
      .assert_sel  (assert_sel),
      .return_sel  (return_sel),
      .pin_out     (pin_out),
      .pin_oe      (pin_oe)
   );

   task automatic check(input string tag, input logic eo, input logic ee, input int t);
      n_checks++;
      if (pin_out !== eo || pin_oe !== ee) begin
         n_fails++;
         $display("FAIL %s tick %0d: out/oe actual %b/%b expected %b/%b",
                  tag, t, pin_out, pin_oe, eo, ee);
      end
   endtask

   // One vector of len ticks; expected waveform computed per tick from the requirements.
   task automatic run_vec(input logic [2:0] code, input logic [2:0] fmt,
                          input int asel, input int rsel, input int len, input string tag);
      int  ta = ph[asel];
      int  tr = ph[rsel];
      bit  drv = 1'b1;
      int  f = (fmt > 3'd5) ? 0 : int'(fmt);
      case (code)
         3'd0: m_data = 1'b0;
         3'd1: m_data = 1'b1;
         3'd3: m_data = m_data;
         3'd4: m_data = ~m_data;
         default: drv = 1'b0;
      endcase
      for (int t = 0; t < len; t++) begin
         bit pa  = (t >= ta);
         bit win = pa && (t < tr);
         logic eo = m_out, ee = m_oe;
         if (!drv) ee = 1'b0;
         else case (f)
            1: begin ee = 1'b1; eo = win ? m_data : 1'b1; end
            2: begin ee = 1'b1; eo = win ? m_data : 1'b0; end
            3: begin ee = win; if (win) eo = m_data; end
            4: if (pa) begin ee = 1'b1; eo = win ? m_data : ~m_data; end
            5: begin ee = 1'b1; eo = win ? m_data : ~m_data; end
            default: if (pa) begin ee = 1'b1; eo = m_data; end
         endcase
         if (t == 0) begin
            vec_start  = 1'b1;
            drv_code   = code;
            fmt_sel    = fmt;
            assert_sel = SEL_W'(asel);
            return_sel = SEL_W'(rsel);
         end
         @(posedge clk); #1;
         // R3: scramble vector inputs after tick 0, they must be ignored
         vec_start  = 1'b0;
         drv_code   = ~code;
         fmt_sel    = ~fmt;
         assert_sel = ~SEL_W'(asel);
         return_sel = ~SEL_W'(rsel);
         check(tag, eo, ee, t);
         m_out = eo;
         m_oe  = ee;
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         check("R1 reset idle", 1'b0, 1'b0, i);
      end
   endtask

   task automatic t_no_return;
      run_vec(3'd1, 3'd0, 1, 2, 8, "R6 NR high, R2 latency");
      run_vec(3'd3, 3'd0, 0, 1, 6, "R4 keep under NR");
      run_vec(3'd0, 3'd0, 2, 1, 8, "R6 NR low holds prior level");
   endtask

   task automatic t_rails;
      run_vec(3'd1, 3'd2, 1, 2, 8, "R7 return to 0");
      run_vec(3'd0, 3'd1, 0, 1, 6, "R7 return to 1");
   endtask

   task automatic t_rz;
      run_vec(3'd1, 3'd3, 1, 2, 8, "R8 return to hi-z");
      run_vec(3'd0, 3'd3, 0, 2, 7, "R8 return to hi-z low data");
   endtask

   task automatic t_rc;
      run_vec(3'd0, 3'd4, 1, 2, 8, "R9 return to complement");
   endtask

   task automatic t_sbc;
      run_vec(3'd1, 3'd5, 1, 2, 8, "R10 surround by complement");
      run_vec(3'd4, 3'd5, 1, 2, 8, "R4 toggle under R10");
   endtask

   task automatic t_empty_window;
      run_vec(3'd1, 3'd2, 2, 3, 8, "R11 equal edges zero width");
      run_vec(3'd0, 3'd5, 2, 1, 8, "R11 return before assert");
   endtask

   task automatic t_hiz;
      run_vec(3'd2, 3'd5, 1, 2, 8, "R5 hi-z under surround");
      run_vec(3'd2, 3'd1, 0, 3, 6, "R5 hi-z under return to 1");
      run_vec(3'd3, 3'd5, 1, 2, 6, "R4 data kept across hi-z");
   endtask

   task automatic t_unused_codes;
      run_vec(3'd1, 3'd7, 2, 1, 8, "R12 format 7 as no return");
      run_vec(3'd6, 3'd5, 0, 1, 6, "R12 drive code 6 as hi-z");
   endtask

   initial begin
      t_reset();
      t_no_return();
      t_rails();
      t_rz();
      t_rc();
      t_sbc();
      t_empty_window();
      t_hiz();
      t_unused_codes();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule